// File: doc/BRIEF.md
# Two-Sided Single-Channel DMA Engine

This block is one DMA channel that copies data between two word-wide bus sides, A and B. Software programs a small register set: the control word, the base source and destination addresses and a byte count. The channel is armed with its pause bit set. Writing the control word again with pause cleared launches the transfer. The channel then alternates one read on the source side with one write on the destination side until the count is used up. At that point it clears its in-progress flag and, if enabled, raises an interrupt.

Each side is a request/acknowledge port. A beat is complete in the cycle where request and acknowledge are both high. A transfer runs in groups of one beat, or of four beats when the source side is set to burst. A group starts only when both the source and the destination request-select lines are ready. The sequencer stops only at group boundaries, when software pauses it or aborts it through the reset bit. Each address can increment, wrap inside a window one burst long, or stay truly fixed. The end-of-transfer flags in the count word mark the final beat on the side ports.

Top module: `dma2_channel`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and neither side requests.
- R2: Register reads return data one cycle after the address is applied. The control word keeps only its writable bits (mask 0x7FFFF3FD). Bit 1 reads in-progress and bit 10 reads the interrupt. The count word keeps bits 20:0, 28, 30 and 31 (mask 0xD01FFFFF).
- R3: A control write at offset 0x0 starts a transfer when all of these hold: pause (bit 25) was 1 and is written 0, reset (bit 12) is written 0, the channel is idle, and the count (bits 20:0) is nonzero. The start copies the base registers into the current registers (0x10 source, 0x14 destination, 0x18 count) and sets in-progress. A start request with a zero count does nothing.
- R4: Direction (bits 14:13) selects the sides: 0 A→A, 1 B→A, 2 A→B, 3 B→B. Each beat reads a word from the source side and then writes that same word on the destination side.
- R5: Width fields (bits 21:19 source, 24:22 destination) use 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. The size outputs carry this code. The current count drops by the source width in bytes on each beat and saturates at zero.
- R6: With the increment bit set (15 source, 16 destination), the address advances by the width in bytes. With the truly-fixed bit set (27 source, 28 destination) and increment clear, the address never changes. With both clear, the address is base + ((i·width) mod (4·width)).
- R7: A group is 4 beats when the source side's burst bit is set (bit 17 for A, bit 18 for B), otherwise 1 beat. Request selects are bits 5:2 (source) and 9:6 (destination). Select 15 is always ready; select n uses `dreq_i[n]`. Readiness is sampled only at the start of a group.
- R8: When the count reaches zero, in-progress clears. The interrupt bit 10 is set, and `irq_o` goes high, only if interrupt enable (bit 26) is 1.
- R9: When clear-enable (bit 30) is 1, any write to offset 0x10 clears the interrupt. When bit 30 is 0, a control write with bit 10 set clears it, and writes to 0x10 change nothing.
- R10: Setting reset (bit 12) during a transfer lets the current group finish. The channel then goes idle without an interrupt, leaving the remaining count readable. While reset is written 1, no start occurs.
- R11: Setting pause during a transfer holds the channel at the next group boundary with in-progress still set. Clearing pause resumes the transfer without reloading the current registers.
- R12: On the final beat, the source read shows `x_last` if count bit 31 is set. The destination write shows `x_last` if count bit 30 is set.
- R13: Offset 0x1C reads the channel number parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dreq_i | input | 16 | Peripheral request lines |
| irq_o | output | 1 | Interrupt |
| a_req | output | 1 | Side A beat request |
| a_we | output | 1 | Side A write (else read) |
| a_addr | output | 32 | Side A address |
| a_size | output | 2 | Side A width code |
| a_wdata | output | 32 | Side A write data |
| a_last | output | 1 | Side A end-of-transfer mark |
| a_ack | input | 1 | Side A acknowledge |
| a_rdata | input | 32 | Side A read data |
| b_req | output | 1 | Side B beat request |
| b_we | output | 1 | Side B write (else read) |
| b_addr | output | 32 | Side B address |
| b_size | output | 2 | Side B width code |
| b_wdata | output | 32 | Side B write data |
| b_last | output | 1 | Side B end-of-transfer mark |
| b_ack | input | 1 | Side B acknowledge |
| b_rdata | input | 32 | Side B read data |

## Verification
Register reads are checked one cycle after the address is applied. The start write takes effect at the clock edge that captures it, so the in-progress bit is read back right after the start. The interrupt is set one edge after the last write beat, so it is checked only after polling shows the channel idle. Write beats are scored at the falling edge of the cycle in which request and acknowledge are both high, against a queue the driver computes from the addressing rules. Paused or gated states are held for tens of cycles and then read twice, so a late beat would show up as a changed count.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int B_BUSY   = 1;
  localparam int B_SREQ   = 2;
  localparam int B_DREQ   = 6;
  localparam int B_INTR   = 10;
  localparam int B_ABORT  = 12;
  localparam int B_DIR    = 13;
  localparam int B_SINC   = 15;
  localparam int B_DINC   = 16;
  localparam int B_ABURST = 17;
  localparam int B_BBURST = 18;
  localparam int B_SW     = 19;
  localparam int B_DW     = 22;
  localparam int B_PAUSE  = 25;
  localparam int B_IE     = 26;
  localparam int B_STFIX  = 27;
  localparam int B_DTFIX  = 28;
  localparam int B_CLREN  = 30;
  localparam int C_WEOT   = 30;
  localparam int C_REOT   = 31;
  localparam logic [3:0]  REQ_ALWAYS = 4'd15;
  localparam logic [31:0] CTRL_WMASK = 32'h7FFF_F3FD;

  typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_RD, ST_WR} seq_st_t;

  function automatic logic [2:0] width_bytes(input logic [2:0] w);
    case (w)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] width_code(input logic [2:0] w);
    return (w > 3'd2) ? 2'd2 : w[1:0];
  endfunction
endpackage

// File: rtl/dma2_addr_gen.sv
module dma2_addr_gen #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] cur,
  input  logic [2:0]    step,
  input  logic          incr,
  input  logic          tfix,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] stepw, win_mask, off;

  always_comb begin
    stepw    = AW'(step);
    win_mask = (stepw << 2) - AW'(1);
    off      = cur - base + stepw;
    if (incr)      nxt = cur + stepw;
    else if (tfix) nxt = cur;
    else           nxt = base + (off & win_mask);
  end
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
  import dma2_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 21,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pause,
  input  logic          abort,
  input  logic          gate_ok,
  input  logic          burst,
  input  logic [2:0]    sstep,
  input  logic [2:0]    dstep,
  input  logic          s_inc,
  input  logic          s_tfix,
  input  logic          d_inc,
  input  logic          d_tfix,
  input  logic [AW-1:0] base_src,
  input  logic [AW-1:0] base_dst,
  input  logic [CW-1:0] base_cnt,
  input  logic          ack,
  input  logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done,
  output logic          rd_req,
  output logic          wr_req,
  output logic          last_beat,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic [DW-1:0] hold
);
  localparam int BTW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  seq_st_t       st;
  logic [BTW-1:0] beat, glen_m1;
  logic [AW-1:0]  src_nxt, dst_nxt;
  logic [CW-1:0]  stepc, cnt_nxt;

  dma2_addr_gen #(.AW(AW)) u_src_ag (.base(base_src), .cur(cur_src), .step(sstep),
                                     .incr(s_inc), .tfix(s_tfix), .nxt(src_nxt));
  dma2_addr_gen #(.AW(AW)) u_dst_ag (.base(base_dst), .cur(cur_dst), .step(dstep),
                                     .incr(d_inc), .tfix(d_tfix), .nxt(dst_nxt));

  always_comb begin
    stepc     = CW'(sstep);
    cnt_nxt   = (cur_cnt > stepc) ? cur_cnt - stepc : '0;
    last_beat = (cur_cnt <= stepc);
    glen_m1   = burst ? BTW'(BURST_LEN - 1) : '0;
    busy      = (st != ST_IDLE);
    rd_req    = (st == ST_RD);
    wr_req    = (st == ST_WR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; beat <= '0; done <= 1'b0; hold <= '0;
      cur_src <= '0; cur_dst <= '0; cur_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cur_src <= base_src; cur_dst <= base_dst; cur_cnt <= base_cnt;
          st <= ST_GATE;
        end
        ST_GATE: begin
          if (abort)                 st <= ST_IDLE;
          else if (!pause && gate_ok) begin st <= ST_RD; beat <= '0; end
        end
        ST_RD: if (ack) begin hold <= rdata; st <= ST_WR; end
        ST_WR: if (ack) begin
          cur_src <= src_nxt; cur_dst <= dst_nxt; cur_cnt <= cnt_nxt;
          if (cnt_nxt == '0) begin st <= ST_IDLE; done <= 1'b1; end
          else if (beat == glen_m1) st <= ST_GATE;
          else begin beat <= beat + BTW'(1); st <= ST_RD; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: every completed beat strictly lowers the remaining count
  assert_cnt_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && ack) |=> (cur_cnt < $past(cur_cnt)));
  // R6: a truly fixed source address does not move across a beat
  assert_tfix_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && ack && s_tfix && !s_inc) |=> (cur_src == $past(cur_src)));
  // R6: a wrapping source address stays within one burst window of its base
  assert_window_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && ack && !s_inc && !s_tfix) |-> ((src_nxt - base_src) < (AW'(sstep) << 2)));
  // R10: abort at a group boundary ends the transfer with no completion
  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GATE && abort) |=> (st == ST_IDLE && !done));
endmodule

// File: rtl/dma2_channel.sv
module dma2_channel
  import dma2_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 21,
  parameter int BURST_LEN = 4,
  parameter int CHAN_ID   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [15:0]   dreq_i,
  output logic          irq_o,
  output logic          a_req,
  output logic          a_we,
  output logic [AW-1:0] a_addr,
  output logic [1:0]    a_size,
  output logic [DW-1:0] a_wdata,
  output logic          a_last,
  input  logic          a_ack,
  input  logic [DW-1:0] a_rdata,
  output logic          b_req,
  output logic          b_we,
  output logic [AW-1:0] b_addr,
  output logic [1:0]    b_size,
  output logic [DW-1:0] b_wdata,
  output logic          b_last,
  input  logic          b_ack,
  input  logic [DW-1:0] b_rdata
);
  localparam logic [31:0] CNT_WMASK = 32'((64'd1 << CW) - 64'd1) | 32'hD000_0000;

  logic [31:0]   ctrl_q, cnt_q;
  logic [AW-1:0] bsrc_q, bdst_q;
  logic          intr_q;

  logic          busy, done, rd_req, wr_req, last_beat, start, gate_ok, burst, seq_ack;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] cur_cnt;
  logic [DW-1:0] hold;
  logic          src_side, dst_side;
  logic [3:0]    ssel, dsel;
  logic [2:0]    sw, dw;

  logic [1:0]    side_req, side_we, side_last, side_ack;
  logic [AW-1:0] side_addr  [2];
  logic [1:0]    side_size  [2];
  logic [DW-1:0] side_rdata [2];

  wire wr_ctrl = reg_wr && (reg_addr[4:2] == 3'd0);
  wire wr_clr  = reg_wr && (reg_addr[4:2] == 3'd4);

  always_comb begin
    src_side = ctrl_q[B_DIR];
    dst_side = ctrl_q[B_DIR+1];
    ssel     = ctrl_q[B_SREQ +: 4];
    dsel     = ctrl_q[B_DREQ +: 4];
    sw       = ctrl_q[B_SW +: 3];
    dw       = ctrl_q[B_DW +: 3];
    burst    = src_side ? ctrl_q[B_BBURST] : ctrl_q[B_ABURST];
    gate_ok  = ((ssel == REQ_ALWAYS) || dreq_i[ssel]) &&
               ((dsel == REQ_ALWAYS) || dreq_i[dsel]);
    start    = wr_ctrl && ctrl_q[B_PAUSE] && !reg_wdata[B_PAUSE] &&
               !reg_wdata[B_ABORT] && !busy && (cnt_q[CW-1:0] != '0);
    seq_ack  = rd_req ? side_ack[src_side] : side_ack[dst_side];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; cnt_q <= '0; bsrc_q <= '0; bdst_q <= '0; intr_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr[4:2])
          3'd0: ctrl_q <= reg_wdata & CTRL_WMASK;
          3'd1: bsrc_q <= AW'(reg_wdata);
          3'd2: bdst_q <= AW'(reg_wdata);
          3'd3: cnt_q  <= reg_wdata & CNT_WMASK;
          default: ;
        endcase
      end
      if (done && ctrl_q[B_IE])
        intr_q <= 1'b1;
      else if ((wr_clr && ctrl_q[B_CLREN]) ||
               (wr_ctrl && !ctrl_q[B_CLREN] && reg_wdata[B_INTR]))
        intr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr[4:2])
        3'd0: begin
          reg_rdata         <= ctrl_q;
          reg_rdata[B_BUSY] <= busy;
          reg_rdata[B_INTR] <= intr_q;
        end
        3'd1: reg_rdata <= 32'(bsrc_q);
        3'd2: reg_rdata <= 32'(bdst_q);
        3'd3: reg_rdata <= cnt_q;
        3'd4: reg_rdata <= 32'(cur_src);
        3'd5: reg_rdata <= 32'(cur_dst);
        3'd6: reg_rdata <= 32'(cur_cnt);
        default: reg_rdata <= 32'(CHAN_ID);
      endcase
    end
  end

  assign irq_o = intr_q;

  dma2_seq #(.AW(AW), .DW(DW), .CW(CW), .BURST_LEN(BURST_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(start), .pause(ctrl_q[B_PAUSE]), .abort(ctrl_q[B_ABORT]),
    .gate_ok(gate_ok), .burst(burst), .sstep(width_bytes(sw)), .dstep(width_bytes(dw)),
    .s_inc(ctrl_q[B_SINC]), .s_tfix(ctrl_q[B_STFIX]), .d_inc(ctrl_q[B_DINC]),
    .d_tfix(ctrl_q[B_DTFIX]), .base_src(bsrc_q), .base_dst(bdst_q),
    .base_cnt(cnt_q[CW-1:0]), .ack(seq_ack), .rdata(side_rdata[src_side]),
    .busy(busy), .done(done), .rd_req(rd_req), .wr_req(wr_req), .last_beat(last_beat),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt), .hold(hold));

  assign side_ack      = {b_ack, a_ack};
  assign side_rdata[0] = a_rdata;
  assign side_rdata[1] = b_rdata;

  for (genvar s = 0; s < 2; s++) begin : g_side
    wire rd_here = rd_req && (src_side == 1'(s));
    wire wr_here = wr_req && (dst_side == 1'(s));
    assign side_req[s]  = rd_here || wr_here;
    assign side_we[s]   = wr_here;
    assign side_addr[s] = wr_here ? cur_dst : cur_src;
    assign side_size[s] = wr_here ? width_code(dw) : width_code(sw);
    assign side_last[s] = last_beat && ((wr_here && cnt_q[C_WEOT]) ||
                                        (rd_here && cnt_q[C_REOT]));
  end

  assign a_req = side_req[0];  assign a_we = side_we[0];  assign a_addr = side_addr[0];
  assign a_size = side_size[0]; assign a_wdata = hold;    assign a_last = side_last[0];
  assign b_req = side_req[1];  assign b_we = side_we[1];  assign b_addr = side_addr[1];
  assign b_size = side_size[1]; assign b_wdata = hold;    assign b_last = side_last[1];

  // R3: an accepted start sets in-progress at once
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R8: the interrupt rises only when enable was set
  assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_q) |-> $past(ctrl_q[B_IE]));
  // R1: an idle channel drives no beat on either side
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(a_req || b_req));
endmodule

// File: tb/dma2_channel_tb_top.sv
module dma2_channel_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] dreq_i = '0;
  logic        irq_o;
  logic        a_req, a_we, a_last, a_ack, b_req, b_we, b_last, b_ack;
  logic [31:0] a_addr, a_wdata, a_rdata, b_addr, b_wdata, b_rdata;
  logic [1:0]  a_size, b_size;

  dma2_channel dut_i (.*);

  function automatic logic [31:0] fa(input logic [31:0] ad);
    return {ad[15:0] ^ 16'h5A5A, ad[15:0]};
  endfunction
  function automatic logic [31:0] fb(input logic [31:0] ad);
    return {16'hB00B, ad[15:0] ^ 16'h0F0F};
  endfunction
  assign a_rdata = fa(a_addr);
  assign b_rdata = fb(b_addr);

  always_ff @(posedge clk) begin
    if (rst) begin a_ack <= 1'b0; b_ack <= 1'b0; end
    else begin a_ack <= a_req && !a_ack; b_ack <= b_req && !b_ack; end
  end

  typedef struct { logic [31:0] addr; logic [31:0] data; logic [1:0] size; logic last; } beat_t;
  beat_t exp_q[$];
  int checks = 0, errors = 0, wr_cnt = 0, hs_cnt = 0, rdlast_cnt = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: scores every write beat against the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if ((a_req && a_ack) || (b_req && b_ack)) hs_cnt++;
      if ((a_req && !a_we && a_ack && a_last) || (b_req && !b_we && b_ack && b_last)) rdlast_cnt++;
      for (int s = 0; s < 2; s++) begin
        if (s == 0 ? (a_req && a_we && a_ack) : (b_req && b_we && b_ack)) begin
          beat_t e;
          wr_cnt++;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R4 unexpected write actual=%h expected=none", s == 0 ? a_addr : b_addr);
          end else begin
            e = exp_q.pop_front();
            if (s == 0 ? (a_addr !== e.addr || a_wdata !== e.data || a_size !== e.size || a_last !== e.last)
                       : (b_addr !== e.addr || b_wdata !== e.data || b_size !== e.size || b_last !== e.last)) begin
              errors++;
              $display("FAIL R4/R5/R6/R12 write beat actual=%h/%h/%0d/%0b expected=%h/%h/%0d/%0b",
                       s == 0 ? a_addr : b_addr, s == 0 ? a_wdata : b_wdata,
                       s == 0 ? a_size : b_size, s == 0 ? a_last : b_last,
                       e.addr, e.data, e.size, e.last);
            end
          end
        end
      end
    end
  end

  function automatic int wbytes(input int w); return (w == 0) ? 1 : (w == 1) ? 2 : 4; endfunction
  // mode: 0 increment, 1 wrap in burst window, 2 truly fixed
  function automatic logic [31:0] addr_at(input logic [31:0] base, input int i, input int st, input int mode);
    if (mode == 0) return base + 32'(i * st);
    if (mode == 1) return base + 32'((i * st) % (4 * st));
    return base;
  endfunction

  task automatic push_exp(input int sside, input logic [31:0] sb, input logic [31:0] db, input int cnt,
                          input int sw, input int dw, input int sm, input int dm, input bit weot);
    int ss = wbytes(sw), ds = wbytes(dw);
    int beats = (cnt + ss - 1) / ss;
    for (int i = 0; i < beats; i++) begin
      beat_t e;
      logic [31:0] sa = addr_at(sb, i, ss, sm);
      e.addr = addr_at(db, i, ds, dm);
      e.data = (sside == 0) ? fa(sa) : fb(sa);
      e.size = 2'(dw);
      e.last = weot && (i == beats - 1);
      exp_q.push_back(e);
    end
  endtask

  function automatic logic [31:0] cfg(input int dir, input int sreq, input int dreq, input bit sinc,
                                      input bit dinc, input bit abur, input bit bbur, input int sw,
                                      input int dw, input bit ie, input bit stf, input bit dtf, input bit ce);
    return (32'(sreq) << 2) | (32'(dreq) << 6) | (32'(dir) << 13) | (32'(sinc) << 15) |
           (32'(dinc) << 16) | (32'(abur) << 17) | (32'(bbur) << 18) | (32'(sw) << 19) |
           (32'(dw) << 22) | (32'(ie) << 26) | (32'(stf) << 27) | (32'(dtf) << 28) | (32'(ce) << 30);
  endfunction
  localparam logic [31:0] PAUSE = 32'h0200_0000, ABORT = 32'h0000_1000, INTR = 32'h0000_0400;

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 300; k++) begin
      reg_read(5'h00, v);
      if (!v[1]) break;
    end
  endtask
  task automatic launch(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    reg_write(5'h04, s); reg_write(5'h08, d); reg_write(5'h0C, n);
    reg_write(5'h00, c | PAUSE); reg_write(5'h00, c);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c, v2;
    int h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    reg_read(5'h00, v); check("R1 ctrl", v, 32'h0);
    reg_read(5'h18, v); check("R1 cur count", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 no req", {30'b0, a_req, b_req}, 32'h0);

    // R2 register masks and readback
    reg_write(5'h00, 32'hFFFF_FFFF); reg_read(5'h00, v); check("R2 ctrl mask", v, 32'h7FFF_F3FD);
    reg_write(5'h00, 32'h0);
    reg_write(5'h0C, 32'hFFFF_FFFF); reg_read(5'h0C, v); check("R2 count mask", v, 32'hD01F_FFFF);
    reg_write(5'h04, 32'h1234_5678); reg_read(5'h04, v); check("R2 base src", v, 32'h1234_5678);
    reg_read(5'h1C, v); check("R13 channel id", v, 32'h0);

    // R3 zero count: no start
    h0 = hs_cnt;
    c = cfg(2, 15, 15, 1, 1, 0, 0, 2, 2, 1, 0, 0, 0);
    launch(c, 32'h1000, 32'h2000, 32'h0);
    reg_read(5'h00, v); check("R3 zero count not started", {31'b0, v[1]}, 32'h0);
    repeat (10) @(negedge clk); check("R3 zero count no beats", 32'(hs_cnt - h0), 32'h0);

    // R4/R5/R6/R8: A->B, 32-bit, incrementing, 16 bytes
    push_exp(0, 32'h1000, 32'h2000, 16, 2, 2, 0, 0, 0);
    launch(c, 32'h1000, 32'h2000, 32'd16);
    reg_read(5'h00, v); check("R3 in progress after start", {31'b0, v[1]}, 32'h1);
    wait_idle();
    reg_read(5'h00, v); check("R8 intr bit", {31'b0, v[10]}, 32'h1);
    check("R8 irq", {31'b0, irq_o}, 32'h1);
    reg_read(5'h10, v); check("R6 inc src end", v, 32'h1010);
    reg_read(5'h14, v); check("R6 inc dst end", v, 32'h2010);
    reg_read(5'h18, v); check("R5 count zero", v, 32'h0);
    reg_write(5'h10, 32'h0); check("R9 0x10 ignored without clear-enable", {31'b0, irq_o}, 32'h1);
    reg_read(5'h10, v); check("R9 cur src kept", v, 32'h1010);
    reg_write(5'h00, c | INTR); check("R9 ctrl clear", {31'b0, irq_o}, 32'h0);

    // R4/R6/R7/R12/R9: B->A, 16-bit wrap source, 8-bit truly fixed dest, burst on B
    c = cfg(1, 15, 15, 0, 0, 0, 1, 1, 0, 1, 0, 1, 1);
    push_exp(1, 32'h3000, 32'h4000, 10, 1, 0, 1, 2, 1);
    h0 = rdlast_cnt;
    launch(c, 32'h3000, 32'h4000, 32'hC000_000A);
    wait_idle();
    reg_read(5'h10, v); check("R6 window src end", v, 32'h3002);
    reg_read(5'h14, v); check("R6 truly fixed dst", v, 32'h4000);
    check("R12 read last seen once", 32'(rdlast_cnt - h0), 32'h1);
    reg_write(5'h10, 32'h0); check("R9 clear via 0x10", {31'b0, irq_o}, 32'h0);

    // R7: request gating and burst groups, A->A, select 3
    c = cfg(0, 3, 15, 1, 1, 1, 0, 2, 2, 1, 0, 0, 0);
    push_exp(0, 32'h5000, 32'h6000, 24, 2, 2, 0, 0, 0);
    h0 = hs_cnt;
    launch(c, 32'h5000, 32'h6000, 32'd24);
    repeat (30) @(negedge clk);
    check("R7 no beat while request low", 32'(hs_cnt - h0), 32'h0);
    reg_read(5'h00, v); check("R7 in progress while gated", {31'b0, v[1]}, 32'h1);
    h0 = wr_cnt;
    dreq_i[3] = 1'b1;
    wait (wr_cnt == h0 + 1);
    @(negedge clk); dreq_i[3] = 1'b0;
    repeat (40) @(negedge clk);
    check("R7 burst of four beats", 32'(wr_cnt - h0), 32'd4);
    reg_read(5'h18, v); check("R7 count after one burst", v, 32'd8);
    dreq_i[3] = 1'b1;
    wait_idle();
    check("R7 all beats", 32'(wr_cnt - h0), 32'd6);
    dreq_i[3] = 1'b0;
    reg_write(5'h00, c | INTR);

    // R10: abort mid burst
    c = cfg(2, 15, 15, 1, 1, 1, 0, 2, 2, 1, 0, 0, 0);
    push_exp(0, 32'h7000, 32'h8000, 16, 2, 2, 0, 0, 0);
    launch(c, 32'h7000, 32'h8000, 32'd32);
    reg_write(5'h00, c | ABORT);
    wait_idle();
    reg_read(5'h18, v); check("R10 remaining count", v, 32'd16);
    check("R10 no irq on abort", {31'b0, irq_o}, 32'h0);
    h0 = hs_cnt;
    reg_write(5'h00, c | ABORT | PAUSE); reg_write(5'h00, c | ABORT);
    reg_read(5'h00, v); check("R10 no start under reset", {31'b0, v[1]}, 32'h0);
    check("R10 no beats under reset", 32'(hs_cnt - h0), 32'h0);
    reg_write(5'h00, c);

    // R11: pause mid transfer, single beats
    c = cfg(2, 15, 15, 1, 1, 0, 0, 2, 2, 0, 0, 0, 0);
    push_exp(0, 32'h9000, 32'hA000, 16, 2, 2, 0, 0, 0);
    launch(c, 32'h9000, 32'hA000, 32'd16);
    reg_write(5'h00, c | PAUSE);
    repeat (30) @(negedge clk);
    reg_read(5'h18, v);
    check("R11 paused part way", {31'b0, (v != 0) && (v < 16)}, 32'h1);
    repeat (20) @(negedge clk);
    reg_read(5'h18, v2); check("R11 count held", v2, v);
    reg_read(5'h00, v); check("R11 in progress held", {31'b0, v[1]}, 32'h1);
    reg_write(5'h00, c);
    wait_idle();
    reg_read(5'h10, v); check("R11 resumed without reload", v, 32'h9010);

    repeat (5) @(negedge clk);
    check("R4 expected queue drained", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule